// File: doc/BRIEF.md
# Network Interrupt Aggregation Register Block

This block gathers network interrupt requests raised by individual ports on three interface slots. It folds them into two 16-bit status words where a zero bit marks a pending request. Slot 0 has the first word to itself. Slots 1 and 2 share the second word: slot 1 occupies the low byte and slot 2 starts at bit 8. Each request arrives as a slot number plus a port number on one of two event channels. The set channel raises a request and the clear channel withdraws one. Both channels may fire in the same cycle.

One registered output, the combined network interrupt, stays high while any bit of either status word is zero. A simple 16-bit register bus reads back the two status words and a read/write interrupt mask. It also returns a fixed platform identifier and two presence words, which are built from plain card-present and flash-present inputs. Reads return their data one cycle after the strobe, together with a valid flag.

Top module: `netIntrTop`

## Requirements
- R1: After reset both status words read 0xFFFF, the mask reads 0x0000, `netIrq` is low and `regRvalid` is low.
- R2: A slot 0 event affects bit `port` of the word at offset 0x26. A slot 1 event affects bit `port` of the word at offset 0x28. A slot 2 event affects bit `8+port` of the word at offset 0x28.
- R3: A set event drives its mapped bit to 0 and a clear event drives it to 1. The bit changes at the clock edge that samples the event. When a set and a clear target the same bit in one cycle, the bit ends at 0.
- R4: `netIrq` rises one cycle after the first status bit becomes 0. It falls one cycle after both words return to 0xFFFF.
- R5: A read strobe at one edge places the selected value on `regRdata` with `regRvalid` high after that edge. `regRvalid` is low in cycles that follow no strobe.
- R6: The status words at 0x26 and 0x28 are read-only, and bus writes to them leave their contents unchanged.
- R7: The mask at offset 0x30 stores any 16-bit value written and returns it on read.
- R8: Offset 0x36 reads the platform identifier 0x0080.
- R9: Offset 0x20 reads 0xFFFF, with bit 3 cleared while `slot1Present` is high and bit 11 cleared while `slot2Present` is high.
- R10: Offset 0x3C reads 0xFFFF, with bit 1 cleared while `sysFlashPresent` is high and bit 0 cleared while `slot0FlashPresent` is high.
- R11: Any other offset reads 0x0000, and a write to it changes no readable register.
- R12: An event for slot 3, or one whose bit position (offset plus port) exceeds 15, changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regRd | input | 1 | Register read strobe |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data, valid one cycle after the strobe |
| regRvalid | output | 1 | Read data valid |
| evSetValid | input | 1 | Set-event request |
| evSetSlot | input | 2 | Slot number of the set event |
| evSetPort | input | 4 | Port number of the set event |
| evClrValid | input | 1 | Clear-event request |
| evClrSlot | input | 2 | Slot number of the clear event |
| evClrPort | input | 4 | Port number of the clear event |
| slot1Present | input | 1 | Module present in slot 1 |
| slot2Present | input | 1 | Module present in slot 2 |
| sysFlashPresent | input | 1 | System flash present |
| slot0FlashPresent | input | 1 | Slot-0 flash present |
| netIrq | output | 1 | Combined network interrupt, active high |

## Verification
A set event and a clear event can land on the same status bit in the same cycle. The bench provokes this by driving both channels with an identical slot and port. It then reads the mapped word and expects the bit at 0. It next fires the clear channel alone and expects the bit to return to 1, which confirms that the earlier clear was overridden rather than lost to a decode fault. The checker adds a per-cycle property that every slot 0 set leaves its bit at 0, whatever the clear channel carries.

// File: rtl/netIntrPkg.sv
package netIntrPkg;
  localparam int DATA_W    = 16;
  localparam int SLOT_W    = 2;
  localparam int PORT_W    = 4;
  localparam int NUM_SLOTS = 3;
  localparam int NUM_STAT  = 2;
  localparam int REG_W     = (NUM_STAT > 1) ? $clog2(NUM_STAT) : 1;
  localparam int BIT_W     = $clog2(DATA_W);
  localparam int HIGH_SLOT_OFFSET = 8;

  localparam int ADDR_CARD  = 'h20;
  localparam int ADDR_STAT0 = 'h26;
  localparam int ADDR_STAT1 = 'h28;
  localparam int ADDR_MASK  = 'h30;
  localparam int ADDR_ID    = 'h36;
  localparam int ADDR_FLASH = 'h3C;

  localparam int CARD_SLOT1_BIT  = 3;
  localparam int CARD_SLOT2_BIT  = 11;
  localparam int FLASH_SYS_BIT   = 1;
  localparam int FLASH_SLOT0_BIT = 0;

  typedef enum logic [2:0] {
    RD_NONE, RD_STAT0, RD_STAT1, RD_MASK, RD_ID, RD_CARD, RD_FLASH
  } rdSel_e;

  typedef struct packed {
    logic                              rdEn;
    rdSel_e                            rdSel;
    logic                              maskWe;
    logic [NUM_STAT-1:0][DATA_W-1:0]   setBits;
    logic [NUM_STAT-1:0][DATA_W-1:0]   clrBits;
  } ctrlStrobe_t;

  // slot to status-word table
  function automatic logic slotValid(input logic [SLOT_W-1:0] s);
    return s < SLOT_W'(NUM_SLOTS);
  endfunction

  function automatic logic [REG_W-1:0] slotReg(input logic [SLOT_W-1:0] s);
    return (s == '0) ? REG_W'(0) : REG_W'(1);
  endfunction

  function automatic logic [PORT_W-1:0] slotOffset(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(2)) ? PORT_W'(HIGH_SLOT_OFFSET) : '0;
  endfunction
endpackage

// File: rtl/netIntrCtrl.sv
module netIntrCtrl
  import netIntrPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regRd,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              evSetValid,
  input  logic [SLOT_W-1:0] evSetSlot,
  input  logic [PORT_W-1:0] evSetPort,
  input  logic              evClrValid,
  input  logic [SLOT_W-1:0] evClrSlot,
  input  logic [PORT_W-1:0] evClrPort,
  output ctrlStrobe_t       strobe
);
  function automatic logic [NUM_STAT-1:0][DATA_W-1:0] eventBits(
    input logic              v,
    input logic [SLOT_W-1:0] s,
    input logic [PORT_W-1:0] p
  );
    logic [NUM_STAT-1:0][DATA_W-1:0] r;
    logic [PORT_W:0]                 pos;
    r   = '0;
    pos = {1'b0, slotOffset(s)} + {1'b0, p};
    if (v && slotValid(s) && (pos < (PORT_W+1)'(DATA_W)))
      r[slotReg(s)][pos[BIT_W-1:0]] = 1'b1;
    return r;
  endfunction

  always_comb begin
    strobe         = '0;
    strobe.rdEn    = regRd;
    strobe.rdSel   = RD_NONE;
    case (regAddr)
      ADDR_W'(ADDR_STAT0): strobe.rdSel = RD_STAT0;
      ADDR_W'(ADDR_STAT1): strobe.rdSel = RD_STAT1;
      ADDR_W'(ADDR_MASK):  strobe.rdSel = RD_MASK;
      ADDR_W'(ADDR_ID):    strobe.rdSel = RD_ID;
      ADDR_W'(ADDR_CARD):  strobe.rdSel = RD_CARD;
      ADDR_W'(ADDR_FLASH): strobe.rdSel = RD_FLASH;
      default:             strobe.rdSel = RD_NONE;
    endcase
    strobe.maskWe  = regWr && (regAddr == ADDR_W'(ADDR_MASK));
    strobe.setBits = eventBits(evSetValid, evSetSlot, evSetPort);
    strobe.clrBits = eventBits(evClrValid, evClrSlot, evClrPort);
  end
endmodule

// File: rtl/netIntrDatapath.sv
module netIntrDatapath
  import netIntrPkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VALUE = 16'h0080
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  ctrlStrobe_t                     strobe,
  input  logic [DATA_W-1:0]               regWdata,
  input  logic                            slot1Present,
  input  logic                            slot2Present,
  input  logic                            sysFlashPresent,
  input  logic                            slot0FlashPresent,
  output logic [DATA_W-1:0]               regRdata,
  output logic                            regRvalid,
  output logic                            netIrq,
  output logic [NUM_STAT-1:0][DATA_W-1:0] statusQ,
  output logic [DATA_W-1:0]               maskQ
);
  logic              anyPending;
  logic [DATA_W-1:0] rdNext;
  logic [DATA_W-1:0] cardWord;
  logic [DATA_W-1:0] flashWord;

  // set has priority: it is applied after the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '1;
    end else begin
      for (int g = 0; g < NUM_STAT; g++)
        statusQ[g] <= (statusQ[g] | strobe.clrBits[g]) & ~strobe.setBits[g];
    end
  end

  always_comb begin
    anyPending = 1'b0;
    for (int g = 0; g < NUM_STAT; g++)
      if (statusQ[g] != '1) anyPending = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) netIrq <= 1'b0;
    else       netIrq <= anyPending;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '0;
    else if (strobe.maskWe) maskQ <= regWdata;
  end

  always_comb begin
    cardWord  = '1;
    cardWord[CARD_SLOT1_BIT]   = ~slot1Present;
    cardWord[CARD_SLOT2_BIT]   = ~slot2Present;
    flashWord = '1;
    flashWord[FLASH_SYS_BIT]   = ~sysFlashPresent;
    flashWord[FLASH_SLOT0_BIT] = ~slot0FlashPresent;
  end

  always_comb begin
    case (strobe.rdSel)
      RD_STAT0: rdNext = statusQ[0];
      RD_STAT1: rdNext = statusQ[1];
      RD_MASK:  rdNext = maskQ;
      RD_ID:    rdNext = ID_VALUE;
      RD_CARD:  rdNext = cardWord;
      RD_FLASH: rdNext = flashWord;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRvalid <= 1'b0;
      regRdata  <= '0;
    end else begin
      regRvalid <= strobe.rdEn;
      if (strobe.rdEn) regRdata <= rdNext;
    end
  end
endmodule

// File: rtl/netIntrTop.sv
module netIntrTop
  import netIntrPkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int PLATFORM_CODE = 4,
  parameter int ID_SHIFT      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [15:0]       regWdata,
  output logic [15:0]       regRdata,
  output logic              regRvalid,
  input  logic              evSetValid,
  input  logic [1:0]        evSetSlot,
  input  logic [3:0]        evSetPort,
  input  logic              evClrValid,
  input  logic [1:0]        evClrSlot,
  input  logic [3:0]        evClrPort,
  input  logic              slot1Present,
  input  logic              slot2Present,
  input  logic              sysFlashPresent,
  input  logic              slot0FlashPresent,
  output logic              netIrq
);
  localparam logic [DATA_W-1:0] ID_VALUE = DATA_W'(PLATFORM_CODE << ID_SHIFT);

  ctrlStrobe_t                     strobe;
  logic [NUM_STAT-1:0][DATA_W-1:0] statusQ;
  logic [DATA_W-1:0]               maskQ;

  netIntrCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr),
    .evSetValid(evSetValid), .evSetSlot(evSetSlot), .evSetPort(evSetPort),
    .evClrValid(evClrValid), .evClrSlot(evClrSlot), .evClrPort(evClrPort),
    .strobe(strobe)
  );

  netIntrDatapath #(.ID_VALUE(ID_VALUE)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata),
    .slot1Present(slot1Present), .slot2Present(slot2Present),
    .sysFlashPresent(sysFlashPresent), .slot0FlashPresent(slot0FlashPresent),
    .regRdata(regRdata), .regRvalid(regRvalid), .netIrq(netIrq),
    .statusQ(statusQ), .maskQ(maskQ)
  );
endmodule

// File: rtl/netIntrChecker.sv
module netIntrChecker
  import netIntrPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            regRd,
  input logic                            regWr,
  input logic [ADDR_W-1:0]               regAddr,
  input logic [DATA_W-1:0]               regWdata,
  input logic                            regRvalid,
  input logic                            evSetValid,
  input logic [SLOT_W-1:0]               evSetSlot,
  input logic [PORT_W-1:0]               evSetPort,
  input logic                            evClrValid,
  input logic                            netIrq,
  input logic [NUM_STAT-1:0][DATA_W-1:0] statusQ,
  input logic [DATA_W-1:0]               maskQ
);
  assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[0] != '1 || statusQ[1] != '1) |=> netIrq);

  assert_irq_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[0] == '1 && statusQ[1] == '1) |=> !netIrq);

  assert_rvalid_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> regRvalid);

  assert_rvalid_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !regRd |=> !regRvalid);

  assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!evSetValid && !evClrValid) |=> ($stable(statusQ[0]) && $stable(statusQ[1])));

  assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_W'(ADDR_MASK)) |=> (maskQ == $past(regWdata)));

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evSetValid && evSetSlot == '0) |=> !statusQ[0][$past(evSetPort)]);
endmodule

bind netIntrTop netIntrChecker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .regRd(regRd), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .regRvalid(regRvalid), .evSetValid(evSetValid),
  .evSetSlot(evSetSlot), .evSetPort(evSetPort), .evClrValid(evClrValid),
  .netIrq(netIrq), .statusQ(statusQ), .maskQ(maskQ)
);

// File: tb/netIntrTop_test.sv
module netIntrTop_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 10;
  // {isSet, slot, port, expected word 0x26, expected word 0x28}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 4'd0,  16'hFFFE, 16'hFFFF},
    {1'b1, 2'd1, 4'd3,  16'hFFFE, 16'hFFF7},
    {1'b1, 2'd2, 4'd2,  16'hFFFE, 16'hFBF7},
    {1'b1, 2'd2, 4'd9,  16'hFFFE, 16'hFBF7},
    {1'b1, 2'd3, 4'd0,  16'hFFFE, 16'hFBF7},
    {1'b0, 2'd0, 4'd0,  16'hFFFF, 16'hFBF7},
    {1'b0, 2'd1, 4'd3,  16'hFFFF, 16'hFBFF},
    {1'b1, 2'd0, 4'd15, 16'h7FFF, 16'hFBFF},
    {1'b0, 2'd2, 4'd2,  16'h7FFF, 16'hFFFF},
    {1'b0, 2'd0, 4'd15, 16'hFFFF, 16'hFFFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regRd = 1'b0, regWr = 1'b0;
  logic [7:0] regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic regRvalid;
  logic evSetValid = 1'b0, evClrValid = 1'b0;
  logic [1:0] evSetSlot = '0, evClrSlot = '0;
  logic [3:0] evSetPort = '0, evClrPort = '0;
  logic slot1Present = 1'b0, slot2Present = 1'b0;
  logic sysFlashPresent = 1'b0, slot0FlashPresent = 1'b0;
  logic netIrq;

  int runCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  netIntrTop uut (
    .clk(clk), .rstN(rstN), .regRd(regRd), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .regRvalid(regRvalid),
    .evSetValid(evSetValid), .evSetSlot(evSetSlot), .evSetPort(evSetPort),
    .evClrValid(evClrValid), .evClrSlot(evClrSlot), .evClrPort(evClrPort),
    .slot1Present(slot1Present), .slot2Present(slot2Present),
    .sysFlashPresent(sysFlashPresent), .slot0FlashPresent(slot0FlashPresent),
    .netIrq(netIrq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); regRd = 1'b1; regAddr = a;
    @(posedge clk); #1;
    d = regRdata;
    check("R5 valid", {15'b0, regRvalid}, 16'h1);
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] d;
    readReg(a, d);
    check(req, d, exp);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [15:0] v);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = v;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic fireEvent(input logic isSet, input logic [1:0] s, input logic [3:0] p);
    @(negedge clk);
    if (isSet) begin evSetValid = 1'b1; evSetSlot = s; evSetPort = p; end
    else       begin evClrValid = 1'b1; evClrSlot = s; evClrPort = p; end
    @(negedge clk); evSetValid = 1'b0; evClrValid = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    // R1: values during and after reset
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq in reset", {15'b0, netIrq}, 16'h0);
    check("R1 rvalid in reset", {15'b0, regRvalid}, 16'h0);
    @(negedge clk); rstN = 1'b1;
    readCheck("R1 word0", 8'h26, 16'hFFFF);
    readCheck("R1 word1", 8'h28, 16'hFFFF);
    readCheck("R1 mask", 8'h30, 16'h0000);
    check("R1 irq", {15'b0, netIrq}, 16'h0);

    // R2 R3 R12: table walk
    for (int i = 0; i < NVEC; i++) begin
      fireEvent(VEC[i][38], VEC[i][37:36], VEC[i][35:32]);
      readCheck("R2 R3 R12 word0", 8'h26, VEC[i][31:16]);
      readCheck("R2 R3 R12 word1", 8'h28, VEC[i][15:0]);
      check("R4 irq level", {15'b0, netIrq},
            {15'b0, (VEC[i][31:16] != 16'hFFFF) || (VEC[i][15:0] != 16'hFFFF)});
    end

    // R4: exact timing of the interrupt output
    @(negedge clk); evSetValid = 1'b1; evSetSlot = 2'd0; evSetPort = 4'd4;
    @(posedge clk); #1;
    check("R4 no rise yet", {15'b0, netIrq}, 16'h0);
    @(negedge clk); evSetValid = 1'b0;
    @(posedge clk); #1;
    check("R4 rise", {15'b0, netIrq}, 16'h1);
    @(negedge clk); evClrValid = 1'b1; evClrSlot = 2'd0; evClrPort = 4'd4;
    @(posedge clk); #1;
    check("R4 no fall yet", {15'b0, netIrq}, 16'h1);
    @(negedge clk); evClrValid = 1'b0;
    @(posedge clk); #1;
    check("R4 fall", {15'b0, netIrq}, 16'h0);

    // R3: set and clear on the same bit in the same cycle
    @(negedge clk);
    evSetValid = 1'b1; evSetSlot = 2'd1; evSetPort = 4'd5;
    evClrValid = 1'b1; evClrSlot = 2'd1; evClrPort = 4'd5;
    @(negedge clk); evSetValid = 1'b0; evClrValid = 1'b0;
    readCheck("R3 set wins", 8'h28, 16'hFFDF);
    fireEvent(1'b0, 2'd1, 4'd5);
    readCheck("R3 clear alone", 8'h28, 16'hFFFF);

    // R5: valid drops when no strobe follows
    @(posedge clk); #1;
    check("R5 valid idle", {15'b0, regRvalid}, 16'h0);

    // R6: writes to status words ignored
    fireEvent(1'b1, 2'd2, 4'd0);
    writeReg(8'h28, 16'hFFFF);
    writeReg(8'h26, 16'h0000);
    readCheck("R6 word1 kept", 8'h28, 16'hFEFF);
    readCheck("R6 word0 kept", 8'h26, 16'hFFFF);
    fireEvent(1'b0, 2'd2, 4'd0);

    // R7: mask read/write
    writeReg(8'h30, 16'hA5C3);
    readCheck("R7 mask", 8'h30, 16'hA5C3);

    // R11: unknown offsets
    writeReg(8'h50, 16'h1234);
    readCheck("R11 unknown read", 8'h50, 16'h0000);
    readCheck("R11 mask untouched", 8'h30, 16'hA5C3);
    readCheck("R11 word1 untouched", 8'h28, 16'hFFFF);

    // R8: identifier
    readCheck("R8 id", 8'h36, 16'h0080);

    // R9: module presence
    readCheck("R9 none", 8'h20, 16'hFFFF);
    slot1Present = 1'b1;
    readCheck("R9 slot1", 8'h20, 16'hFFF7);
    slot2Present = 1'b1;
    readCheck("R9 both", 8'h20, 16'hF7F7);
    slot1Present = 1'b0;
    readCheck("R9 slot2", 8'h20, 16'hF7FF);

    // R10: flash presence
    readCheck("R10 none", 8'h3C, 16'hFFFF);
    sysFlashPresent = 1'b1;
    readCheck("R10 system", 8'h3C, 16'hFFFD);
    slot0FlashPresent = 1'b1;
    readCheck("R10 both", 8'h3C, 16'hFFFC);
    sysFlashPresent = 1'b0;
    readCheck("R10 slot0", 8'h3C, 16'hFFFE);

    $display("  [TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule